// File: doc/BRIEF.md
# SPI Message Transfer Sequencer

This block runs one SPI message at a time. A message is a short list of transfer descriptors, and the block walks that list in order. When a message is offered it loads the bus mode and clock divider for the byte shifter and drives chip select low. It then works through the descriptors. For each byte it starts the shifter with the next outgoing byte and, when the shifter signals completion, it captures the returned byte if the descriptor asks for that. When a transfer's byte count runs out, the block waits until that transfer's delay has elapsed. It then either ends the message or moves on to the next descriptor, first pulsing chip select high for one cycle if the finished transfer requests it.

The descriptor store, the transmit byte source, the receive sink and the serial shifter are all outside the block. The block reads descriptors combinationally at the address it presents. The shifter reports three kinds of event: byte done, write collision and mode fault. After a collision the block starts the same byte again. After a mode fault it releases chip select and ends the message with an error. A free-running timebase measures the delays, and the deadline compare uses a wrap-safe signed difference. Shifter events that arrive when no byte is in flight raise a spurious flag and change nothing else.

Top module: `spi_msg_seq`

## Requirements
- R1: After reset, cs_n is 1, and sh_start, msg_take, msg_done, rx_valid and spurious are all 0.
- R2: In idle with msg_valid high, the block pulses msg_take, loads msg_mode onto sh_mode and msg_div onto sh_div, drives cs_n low, and starts the first byte of descriptor 0.
- R3: Each byte of a descriptor with has-tx set is taken in order from tx_data, and each taken byte gives one tx_take pulse. When has-tx is clear, every byte sent is 0x00 and tx_take stays 0.
- R4: A byte-done event for a descriptor with rx-capture set gives one rx_valid pulse carrying sh_rxbyte in the next cycle. With rx-capture clear, rx_valid stays 0.
- R5: A descriptor of length N causes exactly N byte-done events before the block leaves the transfer, not counting collision retries.
- R6: After the final byte-done event of a transfer with delay D, the block acts at max(D,1) cycles. For the last descriptor, msg_done appears max(D,1) cycles after that transfer's final rx_valid. This holds across timebase wraparound for any D below half the timebase range.
- R7: Between two transfers, cs_n goes high for exactly one cycle if the finished transfer has cs-toggle set. Otherwise cs_n stays low.
- R8: After the descriptor marked last finishes its delay, cs_n goes high and msg_done pulses with msg_err 0.
- R9: A write collision causes the same byte to be started again: the previous byte, or 0x00 when has-tx is clear. The remaining length does not change.
- R10: A mode fault during a transfer drives cs_n high, pulses msg_done with msg_err 1, and returns the block to idle, ready for the next message.
- R11: msg_bytes is cleared when a message is taken and grows by each transfer's length when that transfer's delay ends. It is valid with msg_done.
- R12: A byte-done, collision or fault event outside a transfer pulses spurious in the next cycle. It does not change rx_valid, cs_n, msg_err or the message flow.
- R13: A descriptor of length 0 starts no byte and goes straight to its delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | A message is waiting |
| msg_mode | input | MODE_W | Bus mode bits for the message |
| msg_div | input | DIV_W | Clock divider for the message |
| msg_take | output | 1 | Pulse: message accepted |
| desc_addr | output | ADDR_W | Index of the descriptor being read |
| d_len | input | LEN_W | Descriptor byte count |
| d_has_tx | input | 1 | Descriptor has transmit data |
| d_rx_en | input | 1 | Descriptor captures receive data |
| d_delay | input | DLY_W | Delay after the transfer, in cycles |
| d_cs_toggle | input | 1 | Release chip select for one cycle after this transfer |
| d_last | input | 1 | Final descriptor of the message |
| tx_data | input | DATA_W | Head of the transmit byte source |
| tx_take | output | 1 | Pulse: head byte consumed in the previous cycle |
| rx_data | output | DATA_W | Captured receive byte |
| rx_valid | output | 1 | Pulse: rx_data is valid |
| sh_mode | output | MODE_W | Mode bits to the shifter |
| sh_div | output | DIV_W | Divider to the shifter |
| sh_start | output | 1 | Pulse: shift out sh_txbyte |
| sh_txbyte | output | DATA_W | Byte to shift out |
| sh_done | input | 1 | Shifter finished a byte |
| sh_rxbyte | input | DATA_W | Byte received by the shifter |
| sh_wcol | input | 1 | Shifter reports a write collision |
| sh_modf | input | 1 | Shifter reports a mode fault |
| cs_n | output | 1 | Chip select, active low |
| msg_done | output | 1 | Pulse: message finished |
| msg_err | output | 1 | I/O error status, valid with msg_done |
| msg_bytes | output | CNT_W | Completed byte count of the message |
| spurious | output | 1 | Pulse: shifter event arrived outside a transfer |

## Verification
All outputs are registered. sh_start and tx_take follow one cycle after the edge at which the block decides to send. rx_valid follows one cycle after the cycle in which sh_done is high. msg_done follows max(D,1) cycles after the final rx_valid, and the chip-select gap lasts exactly one cycle. The bench drives inputs and samples outputs on the falling edge and stamps each observation with a cycle counter. This lets it compare the gap between the last rx_valid and msg_done against the descriptor delay, and count the cycles in which cs_n is high inside a message. The shifter model takes two cycles per byte and can turn a chosen byte into a collision or a fault.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WAIT = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
  parameter int DLY_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [DLY_W-1:0] delay,
  output logic             expired
);
  localparam int TS_W = DLY_W + 1;

  logic [TS_W-1:0] now_q;
  logic [TS_W-1:0] deadline_q;
  logic [TS_W-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q      <= '0;
      deadline_q <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (arm) deadline_q <= now_q + TS_W'(delay);
    end
  end

  // wrap-safe: deadline reached when (now - deadline) is non-negative
  always_comb begin
    diff    = now_q - deadline_q;
    expired = ~diff[TS_W-1];
  end
endmodule

// File: rtl/spi_seq_bytepath.sv
module spi_seq_bytepath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_new,
  input  logic              resend,
  input  logic              use_tx,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              capture,
  input  logic [DATA_W-1:0] sh_rxbyte,
  output logic              sh_start,
  output logic [DATA_W-1:0] sh_txbyte,
  output logic              tx_take,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  logic              start_q, take_q, rxv_q;
  logic [DATA_W-1:0] held_q, rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      take_q  <= 1'b0;
      rxv_q   <= 1'b0;
      held_q  <= '0;
      rx_q    <= '0;
    end else begin
      start_q <= send_new | resend;
      take_q  <= send_new & use_tx;
      rxv_q   <= capture;
      if (send_new) held_q <= use_tx ? tx_data : '0;
      if (capture)  rx_q   <= sh_rxbyte;
    end
  end

  assign sh_start  = start_q;
  assign sh_txbyte = held_q;
  assign tx_take   = take_q;
  assign rx_valid  = rxv_q;
  assign rx_data   = rx_q;
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int DLY_W  = 15,
  parameter int ADDR_W = 4,
  parameter int MODE_W = 3,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [MODE_W-1:0] msg_mode,
  input  logic [DIV_W-1:0]  msg_div,
  input  logic [LEN_W-1:0]  d_len,
  input  logic              d_has_tx,
  input  logic              d_rx_en,
  input  logic [DLY_W-1:0]  d_delay,
  input  logic              d_cs_toggle,
  input  logic              d_last,
  input  logic              sh_done,
  input  logic              sh_wcol,
  input  logic              sh_modf,
  input  logic              expired,
  output logic              arm,
  output logic [DLY_W-1:0]  arm_delay,
  output logic              send_new,
  output logic              resend,
  output logic              use_tx,
  output logic              capture,
  output logic              msg_take,
  output logic [ADDR_W-1:0] desc_addr,
  output logic [MODE_W-1:0] sh_mode,
  output logic [DIV_W-1:0]  sh_div,
  output logic              cs_n,
  output logic              msg_done,
  output logic              msg_err,
  output logic [CNT_W-1:0]  msg_bytes,
  output logic              spurious,
  output seq_state_e        state
);
  seq_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, cur_len_q;
  logic [DLY_W-1:0]  cur_dly_q;
  logic              last_q, tog_q, has_tx_q, rx_en_q;
  logic              cs_n_q, done_q, err_q, take_q, spur_q;
  logic [MODE_W-1:0] mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  bytes_q;

  logic in_xfer, ev_wcol, ev_modf, ev_done, fin, start_go, start_zero, any_ev;

  always_comb begin
    in_xfer    = (st_q == ST_XFER);
    any_ev     = sh_done | sh_wcol | sh_modf;
    ev_wcol    = in_xfer & sh_wcol;
    ev_modf    = in_xfer & ~sh_wcol & sh_modf;
    ev_done    = in_xfer & ~sh_wcol & ~sh_modf & sh_done;
    fin        = ev_done & (rem_q == LEN_W'(1));
    start_go   = ((st_q == ST_IDLE) & msg_valid)
               | ((st_q == ST_WAIT) & expired & ~last_q & ~tog_q)
               | (st_q == ST_GAP);
    start_zero = start_go & (d_len == '0);
    send_new   = (start_go & (d_len != '0)) | (ev_done & ~fin);
    resend     = ev_wcol;
    use_tx     = start_go ? d_has_tx : has_tx_q;
    capture    = ev_done & rx_en_q;
    arm        = start_zero | fin;
    arm_delay  = start_go ? d_delay : cur_dly_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      cur_len_q <= '0;
      cur_dly_q <= '0;
      last_q    <= 1'b0;
      tog_q     <= 1'b0;
      has_tx_q  <= 1'b0;
      rx_en_q   <= 1'b0;
      cs_n_q    <= 1'b1;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      take_q    <= 1'b0;
      spur_q    <= 1'b0;
      mode_q    <= '0;
      div_q     <= '0;
      bytes_q   <= '0;
    end else begin
      done_q <= 1'b0;
      take_q <= 1'b0;
      spur_q <= ~in_xfer & any_ev;
      case (st_q)
        ST_IDLE: begin
          if (msg_valid) begin
            take_q  <= 1'b1;
            mode_q  <= msg_mode;
            div_q   <= msg_div;
            bytes_q <= '0;
          end
        end
        ST_XFER: begin
          if (ev_modf) begin
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            addr_q <= '0;
            st_q   <= ST_IDLE;
          end else if (ev_done) begin
            rem_q <= rem_q - 1'b1;
            if (fin) begin
              addr_q <= addr_q + 1'b1;
              st_q   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (expired) begin
            bytes_q <= bytes_q + CNT_W'(cur_len_q);
            if (last_q) begin
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              err_q  <= 1'b0;
              addr_q <= '0;
              st_q   <= ST_IDLE;
            end else if (tog_q) begin
              cs_n_q <= 1'b1;
              st_q   <= ST_GAP;
            end
          end
        end
        default: ;
      endcase
      if (start_go) begin
        rem_q     <= d_len;
        cur_len_q <= d_len;
        cur_dly_q <= d_delay;
        last_q    <= d_last;
        tog_q     <= d_cs_toggle;
        has_tx_q  <= d_has_tx;
        rx_en_q   <= d_rx_en;
        cs_n_q    <= 1'b0;
        if (start_zero) begin
          addr_q <= addr_q + 1'b1;
          st_q   <= ST_WAIT;
        end else begin
          st_q   <= ST_XFER;
        end
      end
    end
  end

  assign msg_take  = take_q;
  assign desc_addr = addr_q;
  assign sh_mode   = mode_q;
  assign sh_div    = div_q;
  assign cs_n      = cs_n_q;
  assign msg_done  = done_q;
  assign msg_err   = err_q;
  assign msg_bytes = bytes_q;
  assign spurious  = spur_q;
  assign state     = st_q;
endmodule

// File: rtl/spi_msg_seq.sv
module spi_msg_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int DLY_W  = 15,
  parameter int ADDR_W = 4,
  parameter int MODE_W = 3,
  parameter int DIV_W  = 8,
  localparam int CNT_W = LEN_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [MODE_W-1:0] msg_mode,
  input  logic [DIV_W-1:0]  msg_div,
  output logic              msg_take,
  output logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  d_len,
  input  logic              d_has_tx,
  input  logic              d_rx_en,
  input  logic [DLY_W-1:0]  d_delay,
  input  logic              d_cs_toggle,
  input  logic              d_last,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_take,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic [MODE_W-1:0] sh_mode,
  output logic [DIV_W-1:0]  sh_div,
  output logic              sh_start,
  output logic [DATA_W-1:0] sh_txbyte,
  input  logic              sh_done,
  input  logic [DATA_W-1:0] sh_rxbyte,
  input  logic              sh_wcol,
  input  logic              sh_modf,
  output logic              cs_n,
  output logic              msg_done,
  output logic              msg_err,
  output logic [CNT_W-1:0]  msg_bytes,
  output logic              spurious
);
  logic             arm, expired, send_new, resend, use_tx, capture;
  logic [DLY_W-1:0] arm_delay;
  seq_state_e       seq_state;

  spi_seq_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .arm(arm), .delay(arm_delay), .expired(expired)
  );

  spi_seq_ctrl #(
    .LEN_W(LEN_W), .DLY_W(DLY_W), .ADDR_W(ADDR_W),
    .MODE_W(MODE_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .msg_valid(msg_valid), .msg_mode(msg_mode), .msg_div(msg_div),
    .d_len(d_len), .d_has_tx(d_has_tx), .d_rx_en(d_rx_en),
    .d_delay(d_delay), .d_cs_toggle(d_cs_toggle), .d_last(d_last),
    .sh_done(sh_done), .sh_wcol(sh_wcol), .sh_modf(sh_modf),
    .expired(expired), .arm(arm), .arm_delay(arm_delay),
    .send_new(send_new), .resend(resend), .use_tx(use_tx), .capture(capture),
    .msg_take(msg_take), .desc_addr(desc_addr),
    .sh_mode(sh_mode), .sh_div(sh_div), .cs_n(cs_n),
    .msg_done(msg_done), .msg_err(msg_err), .msg_bytes(msg_bytes),
    .spurious(spurious), .state(seq_state)
  );

  spi_seq_bytepath #(.DATA_W(DATA_W)) u_bytes (
    .clk(clk), .rst(rst),
    .send_new(send_new), .resend(resend), .use_tx(use_tx), .tx_data(tx_data),
    .capture(capture), .sh_rxbyte(sh_rxbyte),
    .sh_start(sh_start), .sh_txbyte(sh_txbyte), .tx_take(tx_take),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );
endmodule

// File: rtl/spi_msg_seq_chk.sv
module spi_msg_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        state,
  input logic              msg_take,
  input logic              cs_n,
  input logic              rx_valid,
  input logic              sh_done,
  input logic              sh_wcol,
  input logic              sh_modf,
  input logic              sh_start,
  input logic [DATA_W-1:0] sh_txbyte,
  input logic              msg_done,
  input logic              msg_err,
  input logic              spurious
);
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_XFER = 2'd1;

  assert_take_selects_R2: assert property (@(posedge clk) disable iff (rst)
    msg_take |-> !cs_n);

  assert_rx_follows_done_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(sh_done && state == S_XFER));

  assert_collision_resend_R9: assert property (@(posedge clk) disable iff (rst)
    $past(sh_wcol && state == S_XFER) |-> (sh_start && $stable(sh_txbyte)));

  assert_fault_aborts_R10: assert property (@(posedge clk) disable iff (rst)
    $past(sh_modf && !sh_wcol && state == S_XFER) |-> (msg_done && msg_err && cs_n));

  assert_done_releases_cs_R8: assert property (@(posedge clk) disable iff (rst)
    msg_done |-> cs_n);

  assert_spurious_outside_R12: assert property (@(posedge clk) disable iff (rst)
    spurious |-> $past(state != S_XFER && (sh_done || sh_wcol || sh_modf)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sh_start);
endmodule

bind spi_msg_seq spi_msg_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .state(seq_state), .msg_take(msg_take), .cs_n(cs_n),
  .rx_valid(rx_valid), .sh_done(sh_done), .sh_wcol(sh_wcol), .sh_modf(sh_modf),
  .sh_start(sh_start), .sh_txbyte(sh_txbyte), .msg_done(msg_done),
  .msg_err(msg_err), .spurious(spurious)
);

// File: tb/tb_spi_msg_seq.sv
`timescale 1ns/1ps
module tb_spi_msg_seq;
  localparam int DATA_W = 8, LEN_W = 8, DLY_W = 7, ADDR_W = 4, MODE_W = 3, DIV_W = 8;
  localparam int CNT_W = LEN_W + ADDR_W;
  localparam int SH_LAT = 2;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic msg_valid = 1'b0;
  logic [MODE_W-1:0] msg_mode = '0;
  logic [DIV_W-1:0] msg_div = '0;
  logic msg_take, tx_take, rx_valid, sh_start, cs_n, msg_done, msg_err, spurious;
  logic [ADDR_W-1:0] desc_addr;
  logic [LEN_W-1:0] d_len;
  logic d_has_tx, d_rx_en, d_cs_toggle, d_last;
  logic [DLY_W-1:0] d_delay;
  logic [DATA_W-1:0] tx_data, rx_data, sh_txbyte;
  logic [MODE_W-1:0] sh_mode;
  logic [DIV_W-1:0] sh_div;
  logic [CNT_W-1:0] msg_bytes;
  logic sh_done = 1'b0, sh_wcol = 1'b0, sh_modf = 1'b0;
  logic [DATA_W-1:0] sh_rxbyte = '0;

  logic [LEN_W-1:0] dl_len [16];
  logic dl_tx [16], dl_rx [16], dl_tog [16], dl_last [16];
  logic [DLY_W-1:0] dl_dly [16];
  logic [DATA_W-1:0] tx_mem [64];
  int tx_ptr = 0;

  assign d_len = dl_len[desc_addr];
  assign d_has_tx = dl_tx[desc_addr];
  assign d_rx_en = dl_rx[desc_addr];
  assign d_delay = dl_dly[desc_addr];
  assign d_cs_toggle = dl_tog[desc_addr];
  assign d_last = dl_last[desc_addr];
  assign tx_data = tx_mem[tx_ptr % 64];

  spi_msg_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DLY_W(DLY_W), .ADDR_W(ADDR_W),
                .MODE_W(MODE_W), .DIV_W(DIV_W)) dut (.*);

  int vectors = 0, miscompares = 0, cyc = 0;
  int n_sent = 0, n_rx = 0, n_take = 0, n_txtake = 0, n_spur = 0, hi_cnt = 0;
  int last_rx_cyc = 0, done_cyc = 0, wcol_at = -1, modf_at = -1;
  logic [DATA_W-1:0] sent [64];
  logic [DATA_W-1:0] rxl [64];
  logic done_seen = 0, done_err = 0, in_msg = 0, inj_done = 0, inj_modf = 0;
  int done_bytes = 0;
  logic busy = 0;
  int cnt = 0, cur_idx = 0;
  logic [DATA_W-1:0] cur_byte = '0;

  // shifter model and monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    sh_done = 0; sh_wcol = 0; sh_modf = 0;
    if (inj_done) begin sh_done = 1; inj_done = 0; end
    if (inj_modf) begin sh_modf = 1; inj_modf = 0; end
    if (busy) begin
      if (cnt == 0) begin
        busy = 0;
        if (cur_idx == wcol_at) begin sh_wcol = 1; wcol_at = -1; end
        else if (cur_idx == modf_at) begin sh_modf = 1; modf_at = -1; end
        else begin sh_done = 1; sh_rxbyte = ~cur_byte; end
      end else cnt--;
    end
    if (sh_start) begin
      busy = 1; cnt = SH_LAT - 1; cur_byte = sh_txbyte; cur_idx = n_sent;
      if (n_sent < 64) sent[n_sent] = sh_txbyte;
      n_sent++;
    end
    if (msg_take) begin n_take++; msg_valid = 0; in_msg = 1; end
    if (tx_take) begin tx_ptr++; n_txtake++; end
    if (rx_valid) begin
      if (n_rx < 64) rxl[n_rx] = rx_data;
      n_rx++; last_rx_cyc = cyc;
    end
    if (in_msg && !msg_done && cs_n) hi_cnt++;
    if (msg_done) begin
      done_seen = 1; done_err = msg_err; done_bytes = int'(msg_bytes);
      done_cyc = cyc; in_msg = 0;
    end
    if (spurious) n_spur++;
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_sent = 0; n_rx = 0; n_take = 0; n_txtake = 0; n_spur = 0; hi_cnt = 0;
    done_seen = 0; done_err = 0; done_bytes = -1; tx_ptr = 0;
  endtask

  task automatic set_desc(input int i, input int len, input bit tx, input bit rx,
                          input int dly, input bit tog, input bit last);
    dl_len[i] = LEN_W'(len); dl_tx[i] = tx; dl_rx[i] = rx;
    dl_dly[i] = DLY_W'(dly); dl_tog[i] = tog; dl_last[i] = last;
  endtask

  task automatic run_msg(input int mode, input int div);
    @(negedge clk);
    clear_logs();
    msg_mode = MODE_W'(mode); msg_div = DIV_W'(div);
    msg_valid = 1;
    for (int k = 0; k < 3000 && !done_seen; k++) @(negedge clk);
    if (!done_seen) check("watchdog message end", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 cs_n after reset", cs_n, 1);
    check("R1 sh_start after reset", sh_start, 0);
    check("R1 msg_done after reset", msg_done, 0);
    check("R1 msg_take after reset", msg_take, 0);
    check("R1 rx_valid/spurious after reset", rx_valid | spurious, 0);
  endtask

  task automatic t_basic();
    tx_mem[0] = 8'hA5; tx_mem[1] = 8'h3C; tx_mem[2] = 8'hF0;
    set_desc(0, 3, 1, 1, 0, 0, 1);
    run_msg(5, 8'h12);
    check("R2 one take", n_take, 1);
    check("R2 sh_mode loaded", sh_mode, 5);
    check("R2 sh_div loaded", sh_div, 8'h12);
    check("R5 bytes started", n_sent, 3);
    for (int i = 0; i < 3; i++) check("R3 tx order", sent[i], tx_mem[i]);
    check("R3 tx_take count", n_txtake, 3);
    check("R4 rx count", n_rx, 3);
    for (int i = 0; i < 3; i++) check("R4 rx data", rxl[i], (~tx_mem[i]) & 8'hFF);
    check("R8 no error", done_err, 0);
    check("R8 cs_n released", cs_n, 1);
    check("R11 completed length", done_bytes, 3);
    check("R6 zero delay timing", done_cyc - last_rx_cyc, 1);
    check("R7 no cs gap single", hi_cnt, 0);
  endtask

  task automatic t_notx();
    set_desc(0, 4, 0, 0, 2, 0, 1);
    run_msg(2, 1);
    check("R5 bytes started notx", n_sent, 4);
    for (int i = 0; i < 4; i++) check("R3 zero fill", sent[i], 0);
    check("R3 no tx_take", n_txtake, 0);
    check("R4 no rx when capture off", n_rx, 0);
    check("R11 completed length notx", done_bytes, 4);
  endtask

  task automatic t_toggle();
    for (int i = 0; i < 3; i++) tx_mem[i] = 8'(8'h10 + i);
    set_desc(0, 2, 1, 1, 3, 1, 0);
    set_desc(1, 1, 1, 1, 0, 0, 1);
    run_msg(1, 3);
    check("R7 one-cycle cs gap", hi_cnt, 1);
    check("R5 bytes two transfers", n_sent, 3);
    check("R3 order across transfers", sent[2], 8'h12);
    check("R11 sum of lengths", done_bytes, 3);
  endtask

  task automatic t_keep_delay();
    set_desc(0, 1, 1, 1, 5, 0, 0);
    set_desc(1, 2, 1, 1, 9, 0, 1);
    run_msg(0, 0);
    check("R7 cs held low", hi_cnt, 0);
    check("R6 delay 9 timing", done_cyc - last_rx_cyc, 9);
    check("R11 sum keep", done_bytes, 3);
  endtask

  task automatic t_wrap();
    set_desc(0, 1, 0, 1, 100, 0, 1);
    for (int m = 0; m < 4; m++) begin
      run_msg(0, 0);
      check("R6 delay 100 across wrap", done_cyc - last_rx_cyc, 100);
    end
  endtask

  task automatic t_wcol();
    tx_mem[0] = 8'h11; tx_mem[1] = 8'h22; tx_mem[2] = 8'h33;
    set_desc(0, 3, 1, 1, 0, 0, 1);
    wcol_at = 1;
    run_msg(0, 0);
    check("R9 retry adds one start", n_sent, 4);
    check("R9 same byte resent", sent[2], 8'h22);
    check("R9 length unchanged rx", n_rx, 3);
    check("R9 tx_take not repeated", n_txtake, 3);
    check("R11 length after retry", done_bytes, 3);
  endtask

  task automatic t_wcol_zero();
    set_desc(0, 2, 0, 0, 0, 0, 1);
    wcol_at = 0;
    run_msg(0, 0);
    check("R9 zero byte resent", sent[1], 0);
    check("R9 starts with retry notx", n_sent, 3);
  endtask

  task automatic t_modf();
    set_desc(0, 4, 1, 1, 0, 0, 1);
    modf_at = 1;
    run_msg(0, 0);
    check("R10 error status", done_err, 1);
    check("R10 cs_n released", cs_n, 1);
    check("R10 bytes before fault", n_rx, 1);
    check("R11 nothing completed", done_bytes, 0);
    set_desc(0, 1, 1, 1, 0, 0, 1);
    run_msg(0, 0);
    check("R10 next message accepted", n_take, 1);
    check("R10 next message ok", done_err, 0);
  endtask

  task automatic t_zero();
    set_desc(0, 0, 1, 1, 3, 0, 1);
    run_msg(0, 0);
    check("R13 no byte started", n_sent, 0);
    check("R13 no rx", n_rx, 0);
    check("R13 completes clean", done_err, 0);
    check("R13 zero length", done_bytes, 0);
  endtask

  task automatic t_spurious();
    @(negedge clk);
    clear_logs();
    inj_done = 1;
    repeat (4) @(negedge clk);
    check("R12 idle event flagged", n_spur, 1);
    check("R12 idle no rx", n_rx, 0);
    check("R12 idle cs_n high", cs_n, 1);
    check("R12 idle no take", n_take, 0);
    // event during the delay of a transfer
    set_desc(0, 1, 1, 1, 30, 0, 1);
    @(negedge clk);
    clear_logs();
    msg_valid = 1;
    for (int k = 0; k < 200 && n_rx == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    inj_done = 1; inj_modf = 1;
    for (int k = 0; k < 300 && !done_seen; k++) @(negedge clk);
    check("R12 wait event flagged", n_spur, 1);
    check("R12 wait rx unchanged", n_rx, 1);
    check("R12 wait no error", done_err, 0);
    check("R12 wait length", done_bytes, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) set_desc(i, 1, 0, 0, 0, 0, 1);
    for (int i = 0; i < 64; i++) tx_mem[i] = 8'(i * 7 + 1);
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_notx();
    t_toggle();
    t_keep_delay();
    t_wrap();
    t_wcol();
    t_wcol_zero();
    t_modf();
    t_zero();
    t_spurious();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule